// File: doc/BRIEF.md
# T1 Transmit Payload Conditioner

This block sits in the transmit path of a T1 framer. It takes the system-side payload of each outgoing 193-bit frame, one byte per time slot over 24 slots, and it outputs the F-bit for each frame. It applies two changes to each slot. The first is robbed-bit signaling: in two frames of every 12-frame superframe, the least significant bit of a slot is replaced with a signaling bit. The second is B7 zero code suppression: a slot byte that would leave the block as all zeros has one bit forced high instead. A 24-bit clear-channel mask exempts chosen slots from both changes. The mask is written as three bytes and takes effect only at a frame boundary.

The input is a byte stream. A valid strobe marks each slot beat and a start-of-frame marker flags the first slot of a frame. The block counts slots from that marker and tracks the frame number within the superframe. A superframe-start input re-anchors that count. Signaling bits are offered from two sources, and a configuration bit selects between them. In transparent mode the outgoing F-bit is not taken from the system input. It is taken from the last bit of a chosen FS/DL slot of the system stream. Every output appears one clock (one slot) after its input beat, with the frame marker kept aligned.

Bit numbering: `data[7]` is the first bit sent on the line (T1 bit 1) and `data[0]` is the last (T1 bit 8). T1 bit 7 is therefore `data[1]`.

Top module: `t1_tx_payload_cond`

## Requirements
- R1: While `rst_n` is low, and after reset until the first input beat, `out_valid`, `out_sof`, `out_fbit` and `out_data` are all zero.
- R2: `out_valid` and `out_sof` repeat `in_valid` and `in_valid && in_sof` one clock later. `out_data` carries the processed byte of the beat from the previous clock and holds its value on clocks without a beat.
- R3: The frame number runs 1 to 12 and steps on each beat with `in_sof`. It wraps from 12 to 1. The first frame after reset is frame 1. A beat with `in_sof` and `sf_start` both high makes that frame frame 1.
- R4: In a slot that is not a clear channel, `data[0]` is replaced with the A bit in frame 6 and with the B bit in frame 12. In all other frames the byte is not changed by signaling.
- R5: In a slot that is not a clear channel, a byte that is 8'h00 after R4 leaves as 8'h02 (T1 bit 7 forced to one). No such slot ever leaves as 8'h00.
- R6: A slot marked as a clear channel leaves with exactly its input byte: no signaling bit and no zero suppression.
- R7: The beat with `in_sof` is slot 0, and each following beat is the next slot. Mask byte k, written through `mask_wr_idx` = k, bit j, marks slot 8k+j as clear when the bit is 1.
- R8: A mask write is held in a shadow register. It governs processing only from the next beat with `in_sof`. A write in the same clock as such a beat applies from the frame after it.
- R9: When `cfg_sig_ext` is 1, the A and B bits come from `sig_ext_a`/`sig_ext_b`. When it is 0, they come from `sig_int_a`/`sig_int_b`. Clear channels ignore both sources.
- R10: `out_fbit` changes only one clock after a beat with `in_sof`. With `cfg_transparent` = 0 it takes that beat's `in_fbit`. With `cfg_transparent` = 1 it takes `data[0]` of the raw input byte from slot `cfg_fsdl_slot` of the preceding frame, or 0 if no such byte has been seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot beat at most per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input slot beat strobe |
| in_sof | input | 1 | Beat is slot 0 of a frame |
| in_data | input | 8 | System-side slot byte |
| in_fbit | input | 1 | System F-bit, sampled on the slot-0 beat |
| sf_start | input | 1 | Frame starting on this slot-0 beat is frame 1 |
| sig_int_a | input | 1 | Internal-source A signaling bit for this slot |
| sig_int_b | input | 1 | Internal-source B signaling bit for this slot |
| sig_ext_a | input | 1 | External-source A signaling bit for this slot |
| sig_ext_b | input | 1 | External-source B signaling bit for this slot |
| cfg_sig_ext | input | 1 | Select external signaling source |
| cfg_transparent | input | 1 | F-bit taken from the FS/DL slot |
| cfg_fsdl_slot | input | 5 | Slot index carrying the FS/DL bit |
| mask_wr_en | input | 1 | Clear-channel mask byte write strobe |
| mask_wr_idx | input | 2 | Mask byte select (0..2) |
| mask_wr_data | input | 8 | Mask byte value |
| out_valid | output | 1 | Output slot beat strobe |
| out_sof | output | 1 | Output beat is slot 0 |
| out_data | output | 8 | Conditioned slot byte |
| out_fbit | output | 1 | F-bit for the frame starting at `out_sof` |

## Verification
The bound checker watches several rules on every clock. These are the one-clock alignment of the valid and frame strobes, and that a clear-channel byte leaves the block untouched. They also cover that no suppressed slot is ever emitted as zero, that the frame number stays within its 1 to 12 range, that a superframe start forces frame 1, and that the F-bit holds between frame starts. Some behaviour involves history over many beats, and only the bench's frame sequences can show it: the exact signaling bit placed in frames 6 and 12 for each source, the wrap of the superframe count, the deferral of mask writes to a frame boundary (including a write that lands on the boundary itself), and the transparent F-bit carried over from the previous frame's FS/DL slot.

// File: rtl/t1c_pkg.sv
package t1c_pkg;
  localparam int SLOT_W = 8;
  typedef logic [SLOT_W-1:0] slot_byte_t;

  typedef struct packed {
    logic a;
    logic b;
  } sig_pair_t;
endpackage

// File: rtl/t1c_mask_bank.sv
// Clear-channel mask: byte-written shadow copy, frame-aligned active copy.
module t1c_mask_bank #(
  parameter int NUM_SLOTS = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [((((NUM_SLOTS+7)/8) > 1) ? $clog2((NUM_SLOTS+7)/8) : 1)-1:0] wr_idx,
  input  t1c_pkg::slot_byte_t  wr_data,
  input  logic                 frame_start,
  output logic [NUM_SLOTS-1:0] mask_eff
);
  localparam int NBYTES = (NUM_SLOTS + 7) / 8;
  localparam int IW     = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int SH_W   = NBYTES * 8;

  logic [SH_W-1:0]      shadow_q, shadow_d;
  logic [NUM_SLOTS-1:0] active_q, active_d;

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    always_comb begin
      shadow_d[k*8 +: 8] = shadow_q[k*8 +: 8];
      if (wr_en && (wr_idx == IW'(k))) begin
        shadow_d[k*8 +: 8] = wr_data;
      end
    end
  end

  // The active copy is refreshed from the shadow on the slot-0 beat and
  // used in that same beat, so a frame never sees a half-written mask.
  always_comb begin
    active_d = active_q;
    mask_eff = active_q;
    if (frame_start) begin
      active_d = shadow_q[NUM_SLOTS-1:0];
      mask_eff = shadow_q[NUM_SLOTS-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end
endmodule

// File: rtl/t1c_frame_track.sv
// Slot index within the frame and frame number within the superframe.
module t1c_frame_track #(
  parameter int NUM_SLOTS = 24,
  parameter int SF_LEN    = 12,
  localparam int SW = $clog2(NUM_SLOTS),
  localparam int FW = $clog2(SF_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          sof,
  input  logic          sf_start,
  output logic [SW-1:0] slot_eff,
  output logic [FW-1:0] frame_eff
);
  localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
  localparam logic [FW-1:0] LAST_FRM  = FW'(SF_LEN);
  localparam logic [FW-1:0] FIRST_FRM = FW'(1);

  logic [SW-1:0] slot_q;
  logic [FW-1:0] frame_q;
  logic          sof_beat;

  assign sof_beat = beat && sof;

  always_comb begin
    slot_eff  = slot_q;
    frame_eff = frame_q;
    if (sof_beat) begin
      slot_eff = '0;
      if (sf_start || (frame_q == LAST_FRM)) begin
        frame_eff = FIRST_FRM;
      end else begin
        frame_eff = frame_q + FW'(1);
      end
    end else if (beat && (slot_q != LAST_SLOT)) begin
      slot_eff = slot_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= LAST_SLOT;
      frame_q <= LAST_FRM;
    end else if (beat) begin
      slot_q  <= slot_eff;
      frame_q <= frame_eff;
    end
  end
endmodule

// File: rtl/t1c_slot_cond.sv
// Per-slot byte conditioning: robbed-bit insertion, then B7 stuffing.
module t1c_slot_cond #(
  parameter int FW          = 4,
  parameter int SIG_A_FRAME = 6,
  parameter int SIG_B_FRAME = 12
) (
  input  t1c_pkg::slot_byte_t data_in,
  input  logic                clear,
  input  logic [FW-1:0]       frame,
  input  t1c_pkg::sig_pair_t  sig,
  output t1c_pkg::slot_byte_t data_out
);
  localparam logic [FW-1:0] A_FRM = FW'(SIG_A_FRAME);
  localparam logic [FW-1:0] B_FRM = FW'(SIG_B_FRAME);
  localparam t1c_pkg::slot_byte_t B7_ONE = t1c_pkg::slot_byte_t'(2);

  t1c_pkg::slot_byte_t robbed;

  always_comb begin
    robbed = data_in;
    if (!clear && (frame == A_FRM)) begin
      robbed[0] = sig.a;
    end else if (!clear && (frame == B_FRM)) begin
      robbed[0] = sig.b;
    end
  end

  always_comb begin
    data_out = robbed;
    if (!clear && (robbed == '0)) begin
      data_out = B7_ONE;
    end
  end
endmodule

// File: rtl/t1c_fbit_sel.sv
// Outgoing F-bit: system input or the FS/DL slot's last bit of the prior frame.
module t1c_fbit_sel #(
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat,
  input  logic          sof,
  input  logic [SW-1:0] slot_eff,
  input  logic [SW-1:0] fsdl_slot,
  input  logic          data_lsb,
  input  logic          transparent,
  input  logic          fbit_in,
  output logic          fbit_out
);
  logic fsdl_q, fsdl_d;
  logic fbit_q, fbit_d;

  always_comb begin
    fsdl_d = fsdl_q;
    fbit_d = fbit_q;
    if (beat && sof) begin
      fbit_d = transparent ? fsdl_q : fbit_in;
    end
    if (beat && (slot_eff == fsdl_slot)) begin
      fsdl_d = data_lsb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsdl_q <= 1'b0;
      fbit_q <= 1'b0;
    end else begin
      fsdl_q <= fsdl_d;
      fbit_q <= fbit_d;
    end
  end

  assign fbit_out = fbit_q;
endmodule

// File: rtl/t1_tx_payload_cond.sv
module t1_tx_payload_cond #(
  parameter int NUM_SLOTS   = 24,
  parameter int SF_LEN      = 12,
  parameter int SIG_A_FRAME = 6,
  parameter int SIG_B_FRAME = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  in_valid,
  input  logic                                  in_sof,
  input  logic [7:0]                            in_data,
  input  logic                                  in_fbit,
  input  logic                                  sf_start,
  input  logic                                  sig_int_a,
  input  logic                                  sig_int_b,
  input  logic                                  sig_ext_a,
  input  logic                                  sig_ext_b,
  input  logic                                  cfg_sig_ext,
  input  logic                                  cfg_transparent,
  input  logic [$clog2(NUM_SLOTS)-1:0]          cfg_fsdl_slot,
  input  logic                                  mask_wr_en,
  input  logic [$clog2((NUM_SLOTS+7)/8)-1:0]    mask_wr_idx,
  input  logic [7:0]                            mask_wr_data,
  output logic                                  out_valid,
  output logic                                  out_sof,
  output logic [7:0]                            out_data,
  output logic                                  out_fbit
);
  localparam int SW = $clog2(NUM_SLOTS);
  localparam int FW = $clog2(SF_LEN + 1);

  logic [NUM_SLOTS-1:0] mask_eff;
  logic [SW-1:0]        slot_eff;
  logic [FW-1:0]        frame_eff;
  logic                 clear_hit;
  logic                 sof_beat;
  t1c_pkg::sig_pair_t   sig_sel;
  t1c_pkg::slot_byte_t  cond_byte;

  logic                 valid_q, sof_q;
  t1c_pkg::slot_byte_t  data_q, data_d;

  assign sof_beat = in_valid && in_sof;

  t1c_mask_bank #(.NUM_SLOTS(NUM_SLOTS)) u_mask (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (mask_wr_en),
    .wr_idx      (mask_wr_idx),
    .wr_data     (mask_wr_data),
    .frame_start (sof_beat),
    .mask_eff    (mask_eff)
  );

  t1c_frame_track #(.NUM_SLOTS(NUM_SLOTS), .SF_LEN(SF_LEN)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat      (in_valid),
    .sof       (in_sof),
    .sf_start  (sf_start),
    .slot_eff  (slot_eff),
    .frame_eff (frame_eff)
  );

  assign clear_hit = mask_eff[slot_eff];

  always_comb begin
    if (cfg_sig_ext) begin
      sig_sel.a = sig_ext_a;
      sig_sel.b = sig_ext_b;
    end else begin
      sig_sel.a = sig_int_a;
      sig_sel.b = sig_int_b;
    end
  end

  t1c_slot_cond #(
    .FW          (FW),
    .SIG_A_FRAME (SIG_A_FRAME),
    .SIG_B_FRAME (SIG_B_FRAME)
  ) u_cond (
    .data_in  (in_data),
    .clear    (clear_hit),
    .frame    (frame_eff),
    .sig      (sig_sel),
    .data_out (cond_byte)
  );

  t1c_fbit_sel #(.SW(SW)) u_fbit (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat        (in_valid),
    .sof         (in_sof),
    .slot_eff    (slot_eff),
    .fsdl_slot   (cfg_fsdl_slot),
    .data_lsb    (in_data[0]),
    .transparent (cfg_transparent),
    .fbit_in     (in_fbit),
    .fbit_out    (out_fbit)
  );

  always_comb begin
    data_d = data_q;
    if (in_valid) begin
      data_d = cond_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      sof_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= in_valid;
      sof_q   <= sof_beat;
      data_q  <= data_d;
    end
  end

  assign out_valid = valid_q;
  assign out_sof   = sof_q;
  assign out_data  = data_q;
endmodule

// File: rtl/t1c_tx_cond_chk.sv
module t1c_tx_cond_chk #(
  parameter int FW     = 4,
  parameter int SF_LEN = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_sof,
  input logic [7:0]    in_data,
  input logic          sf_start,
  input logic          out_valid,
  input logic          out_sof,
  input logic [7:0]    out_data,
  input logic          out_fbit,
  input logic          clear_hit,
  input logic [FW-1:0] frame_eff
);
  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  idle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  sof_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> out_sof);
  // R6
  clear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && clear_hit) |=> (out_data == $past(in_data)));
  // R5
  no_zero_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clear_hit) |=> (out_data != 8'h00));
  // R3
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_eff >= FW'(1)) && (frame_eff <= FW'(SF_LEN)));
  // R3
  sf_anchor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && sf_start) |-> (frame_eff == FW'(1)));
  // R10
  fbit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_sof) |=> $stable(out_fbit));
endmodule

bind t1_tx_payload_cond t1c_tx_cond_chk #(.FW(FW), .SF_LEN(SF_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sof    (in_sof),
  .in_data   (in_data),
  .sf_start  (sf_start),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_data  (out_data),
  .out_fbit  (out_fbit),
  .clear_hit (clear_hit),
  .frame_eff (frame_eff)
);

// File: tb/t1_tx_payload_cond_test.sv
`timescale 1ns/100ps
module t1_tx_payload_cond_test;
  logic       clk;
  logic       rst_n;
  logic       in_valid, in_sof, in_fbit, sf_start;
  logic [7:0] in_data;
  logic       sig_int_a, sig_int_b, sig_ext_a, sig_ext_b;
  logic       cfg_sig_ext, cfg_transparent;
  logic [4:0] cfg_fsdl_slot;
  logic       mask_wr_en;
  logic [1:0] mask_wr_idx;
  logic [7:0] mask_wr_data;
  logic       out_valid, out_sof, out_fbit;
  logic [7:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [23:0] m_shadow = '0;
  logic [23:0] m_active = '0;
  int          m_frame  = 12;
  int          m_slot   = 23;
  logic        m_fsdl   = 1'b0;
  logic        m_fbit   = 1'b0;
  bit          r8_zone  = 0;

  t1_tx_payload_cond uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .in_fbit(in_fbit), .sf_start(sf_start),
    .sig_int_a(sig_int_a), .sig_int_b(sig_int_b),
    .sig_ext_a(sig_ext_a), .sig_ext_b(sig_ext_b),
    .cfg_sig_ext(cfg_sig_ext), .cfg_transparent(cfg_transparent),
    .cfg_fsdl_slot(cfg_fsdl_slot), .mask_wr_en(mask_wr_en),
    .mask_wr_idx(mask_wr_idx), .mask_wr_data(mask_wr_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data),
    .out_fbit(out_fbit)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one input clock: drive at the falling edge, check after the rising edge
  task automatic beat(input bit v, input bit sof, input bit sfs,
                      input logic [7:0] d, input bit fb);
    logic [7:0] e;
    bit clr, a, b, sigf;
    string tag;
    @(negedge clk);
    in_valid = v; in_sof = sof; sf_start = sfs; in_data = d; in_fbit = fb;
    sig_int_a = (m_slot % 2) == 0;
    sig_int_b = ((m_slot / 2) % 2) == 1;
    sig_ext_a = (m_slot % 2) == 1;
    sig_ext_b = ((m_slot / 4) % 2) == 0;
    e = 8'h00; clr = 0; sigf = 0;
    if (v) begin
      if (sof) begin
        m_active = m_shadow;
        m_frame  = (sfs || m_frame == 12) ? 1 : m_frame + 1;
        m_slot   = 0;
      end else if (m_slot < 23) begin
        m_slot++;
      end
      // signaling inputs are functions of the slot being driven now
      sig_int_a = (m_slot % 2) == 0;
      sig_int_b = ((m_slot / 2) % 2) == 1;
      sig_ext_a = (m_slot % 2) == 1;
      sig_ext_b = ((m_slot / 4) % 2) == 0;
      a = cfg_sig_ext ? sig_ext_a : sig_int_a;
      b = cfg_sig_ext ? sig_ext_b : sig_int_b;
      clr = m_active[m_slot];
      e = d;
      if (!clr) begin
        if (m_frame == 6)       begin e[0] = a; sigf = 1; end
        else if (m_frame == 12) begin e[0] = b; sigf = 1; end
        if (e == 8'h00) e = 8'h02;
      end
      if (sof) m_fbit = cfg_transparent ? m_fsdl : fb;
      if (m_slot == int'(cfg_fsdl_slot)) m_fsdl = d[0];
    end
    if (mask_wr_en) m_shadow[mask_wr_idx*8 +: 8] = mask_wr_data;
    @(posedge clk);
    #1;
    mask_wr_en = 1'b0;
    check(out_valid == v, "R2 out_valid", out_valid, v);
    check(out_sof == (v && sof), "R2 out_sof", out_sof, v && sof);
    if (v) begin
      if (r8_zone)               tag = clr ? "R8 clear" : "R8 cond";
      else if (clr)              tag = "R6/R7 clear slot";
      else if (sigf && cfg_sig_ext) tag = "R4/R9 external signaling";
      else if (sigf)             tag = "R3/R4 signaling frame";
      else if (d == 8'h00)       tag = "R5 B7 stuffing";
      else                       tag = "R7 plain slot";
      check(out_data == e, tag, out_data, e);
      if (sof) check(out_fbit == m_fbit, cfg_transparent ? "R10 transparent F-bit" : "R10 system F-bit",
                     out_fbit, m_fbit);
    end
  endtask

  task automatic write_mask(input logic [1:0] idx, input logic [7:0] val);
    @(negedge clk);
    mask_wr_en = 1'b1; mask_wr_idx = idx; mask_wr_data = val;
    m_shadow[idx*8 +: 8] = val;
    @(posedge clk);
    #1;
    mask_wr_en = 1'b0;
  endtask

  function automatic logic [7:0] pattern(input int f, input int s);
    case (s % 3)
      0:       return 8'h00;
      1:       return 8'h01;
      default: return 8'((f * 37 + s * 11) & 8'hFF);
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 0; in_sof = 0; in_fbit = 0; sf_start = 0; in_data = 8'h00;
    sig_int_a = 0; sig_int_b = 0; sig_ext_a = 0; sig_ext_b = 0;
    cfg_sig_ext = 0; cfg_transparent = 0; cfg_fsdl_slot = 5'd3;
    mask_wr_en = 0; mask_wr_idx = 0; mask_wr_data = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(out_valid == 0, "R1 out_valid", out_valid, 0);
    check(out_sof == 0, "R1 out_sof", out_sof, 0);
    check(out_fbit == 0, "R1 out_fbit", out_fbit, 0);
    check(out_data == 8'h00, "R1 out_data", out_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check(out_valid == 0 && out_data == 8'h00, "R1 after release", out_data, 0);

    // clear slots 0, 3, 12, 16 and 23 (R7 layout)
    write_mask(2'd0, 8'h09);
    write_mask(2'd1, 8'h10);
    write_mask(2'd2, 8'h81);

    for (int fr = 0; fr < 30; fr++) begin
      cfg_sig_ext     = (fr >= 12 && fr < 26);
      cfg_transparent = (fr >= 10);
      cfg_fsdl_slot   = (fr < 20) ? 5'd4 : 5'd0;
      r8_zone = (fr == 9) || (fr == 21);
      for (int s = 0; s < 24; s++) begin
        if (fr == 8 && s == 12) begin
          // mid-frame write: slots 8..11 become clear from frame 9 (R8)
          mask_wr_en = 1'b1; mask_wr_idx = 2'd1; mask_wr_data = 8'h0F;
        end
        if (fr == 20 && s == 0) begin
          // write on the slot-0 beat: applies from frame 21 (R8)
          mask_wr_en = 1'b1; mask_wr_idx = 2'd0; mask_wr_data = 8'hF0;
        end
        beat(1'b1, s == 0, (s == 0) && (fr == 0 || fr == 17),
             pattern(fr, s), fr[0]);
      end
      if (fr % 5 == 4) beat(1'b0, 1'b0, 1'b0, 8'h5A, 1'b1);
    end
    beat(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule